// File: doc/BRIEF.md
# Smart-card transmitter with automatic resend

This block sends bytes over a half-duplex smart-card line. Each character is a low start bit, eight data bits with the least significant bit first, and an even parity bit. Every bit lasts one elementary time unit (etu). The etu length is a run-time count of clock cycles. A guard period of two etu follows each character. In that period the block lets go of the line and looks at it half an etu in. A low level there is the receiver's error signal. The block then marks a sticky error status and sends the same byte again as soon as the guard ends, with no help from the host. When the guard passes without an error signal, the character counts as delivered. The done flag and the holding-empty flag then rise together.

A host or a DMA engine loads the byte into a holding register. A host load leaves the flags alone. The host starts the next character by clearing the empty and done flags with a separate strobe. A DMA load clears those flags by itself, but only when the engine says its interrupt-select bit is 0 and its count is not yet zero. The transmit request and the error request are the done flag and the error status, each gated by its own enable. The DMA request stays low for the whole of a resend sequence, because the done flag stays low. The line pin is open-drain: the block only pulls the line low or releases it.

The controller has three states: IDLE, SEND and GUARD. These are its transitions:
- IDLE to SEND (start) when the empty flag is clear.
- SEND to SEND (bit advance) at each etu end.
- SEND to GUARD after the parity bit.
- GUARD to SEND (retry) at the end of the guard when an error signal was seen.
- GUARD to IDLE (done) at the end of the guard when no error signal was seen.

Top module: `cardline_tx`

## Requirements
- R1: A character is sent as start bit 0, then data bits 0..7, then the even-parity bit (the bit equals the XOR of the data bits). Each bit lasts one etu and is driven by pulling `line_drive_low` high for a 0.
- R2: `line_drive_low` is 0 while idle and throughout the guard period (etu 10 and 11 after the start edge).
- R3: If the line is low at 10.5 etu after the start edge, `err_status` is set in the following cycle. `irq_err` is high only when `err_status` and `err_irq_en` are both 1.
- R4: After an error signal, `tx_done` stays 0 and the byte held in the holding register is sent again. The new start bit begins exactly 12 etu after the previous start edge.
- R5: With no error signal, `tx_done` and `hold_empty` both become 1 exactly 12 etu after the start edge. `irq_tx` is high only when `tx_done` and `tx_irq_en` are both 1.
- R6: `dma_req` is `tx_done` AND `hold_empty`. It is 0 during a character and during every resend.
- R7: A DMA write always loads the holding register. It clears `hold_empty` and `tx_done` only when `dma_isel` is 0 and `dma_cnt_nz` is 1. Otherwise both flags keep their value and no character starts.
- R8: `err_status` is never cleared by the block. It stays 1 across later successful characters until `host_clr_err` is pulsed.
- R9: After reset `hold_empty`=1, `tx_done`=1 and `err_status`=0. A host data write alone starts nothing. A character starts once `hold_empty` is cleared while the block is idle.
- R10: The bit length follows `etu_cycles`. The start bit stays low for exactly `etu_cycles` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| etu_cycles | input | ETU_W | Clock cycles per etu (2 or more) |
| tx_irq_en | input | 1 | Enable for the transmit request |
| err_irq_en | input | 1 | Enable for the error request |
| host_wr | input | 1 | Host load strobe for the holding register |
| host_data | input | DATA_W | Host byte |
| host_clr_flags | input | 1 | Host clear of the empty and done flags |
| host_clr_err | input | 1 | Host clear of the error status |
| dma_wr | input | 1 | DMA load strobe for the holding register |
| dma_data | input | DATA_W | DMA byte |
| dma_isel | input | 1 | DMA interrupt-select bit; 1 keeps the flags |
| dma_cnt_nz | input | 1 | DMA remaining count is nonzero |
| line_in | input | 1 | Sensed level of the shared line |
| line_drive_low | output | 1 | 1 pulls the line low, 0 releases it |
| hold_empty | output | 1 | Holding register empty flag |
| tx_done | output | 1 | End-of-transmission flag |
| err_status | output | 1 | Sticky error-signal flag |
| irq_tx | output | 1 | Gated transmit request |
| irq_err | output | 1 | Gated error request |
| dma_req | output | 1 | Transmit request to the DMA engine |

## Verification
The assertions check these behaviours on every cycle:
- The line is released in the guard period and while idle.
- The done flag is never high while a character or resend is in flight.
- The done flag never rises without the empty flag.
- The error status is sticky, and both requests follow their enables.
- A DMA write with select set or count zero leaves the empty flag set.

Only the bench scenarios can show the rest:
- The bit order and parity.
- The exact 12-etu timing of completion and of the resend start.
- That a resend carries the same byte.
- That the etu length follows the programmed count.

// File: rtl/sctx_pkg.sv
package sctx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEND  = 2'd1,
        ST_GUARD = 2'd2
    } tx_state_e;
endpackage

// File: rtl/sctx_etu_timer.sv
module sctx_etu_timer #(
    parameter int ETU_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [ETU_W-1:0] etu_cycles,
    output logic             etu_end,
    output logic             etu_mid
);
    logic [ETU_W-1:0] cnt;

    assign etu_end = run && (cnt == etu_cycles - 1'b1);
    assign etu_mid = run && (cnt == (etu_cycles >> 1));

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (etu_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sctx_flags.sv
module sctx_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_done,
    input  logic set_err,
    input  logic host_clr,
    input  logic err_clr,
    input  logic dma_wr,
    input  logic dma_isel,
    input  logic dma_cnt_nz,
    output logic empty,
    output logic done,
    output logic err
);
    logic auto_clr;

    // a DMA load clears the flags only with select low and count left
    assign auto_clr = dma_wr && !dma_isel && dma_cnt_nz;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty <= 1'b1;
            done  <= 1'b1;
            err   <= 1'b0;
        end else begin
            if (set_done) begin
                empty <= 1'b1;
                done  <= 1'b1;
            end else if (host_clr || auto_clr) begin
                empty <= 1'b0;
                done  <= 1'b0;
            end
            if (set_err) begin
                err <= 1'b1;
            end else if (err_clr) begin
                err <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cardline_tx.sv
module cardline_tx
    import sctx_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ETU_W     = 12,
    parameter int GUARD_ETU = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ETU_W-1:0]  etu_cycles,
    input  logic              tx_irq_en,
    input  logic              err_irq_en,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_data,
    input  logic              host_clr_flags,
    input  logic              host_clr_err,
    input  logic              dma_wr,
    input  logic [DATA_W-1:0] dma_data,
    input  logic              dma_isel,
    input  logic              dma_cnt_nz,
    input  logic              line_in,
    output logic              line_drive_low,
    output logic              hold_empty,
    output logic              tx_done,
    output logic              err_status,
    output logic              irq_tx,
    output logic              irq_err,
    output logic              dma_req
);
    localparam int FRAME_BITS = DATA_W + 2;
    localparam int CNT_W      = $clog2(FRAME_BITS);
    localparam int GCNT_W     = $clog2(GUARD_ETU + 1);
    localparam logic [CNT_W-1:0]  LAST_BIT   = CNT_W'(FRAME_BITS - 1);
    localparam logic [GCNT_W-1:0] LAST_GUARD = GCNT_W'(GUARD_ETU - 1);

    tx_state_e              state, nxt;
    logic [DATA_W-1:0]      hold_q;
    logic [FRAME_BITS-1:0]  shreg;
    logic [CNT_W-1:0]       bit_cnt;
    logic [GCNT_W-1:0]      guard_cnt;
    logic                   nack_q;
    logic                   etu_end, etu_mid;
    logic                   guard_end, load_frame, shift_bit, err_hit, set_done;

    sctx_etu_timer #(.ETU_W(ETU_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (state != ST_IDLE),
        .etu_cycles (etu_cycles),
        .etu_end    (etu_end),
        .etu_mid    (etu_mid)
    );

    sctx_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_done   (set_done),
        .set_err    (err_hit),
        .host_clr   (host_clr_flags),
        .err_clr    (host_clr_err),
        .dma_wr     (dma_wr),
        .dma_isel   (dma_isel),
        .dma_cnt_nz (dma_cnt_nz),
        .empty      (hold_empty),
        .done       (tx_done),
        .err        (err_status)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (!hold_empty) nxt = ST_SEND;
            ST_SEND:  if (etu_end && bit_cnt == LAST_BIT) nxt = ST_GUARD;
            ST_GUARD: if (guard_end) nxt = nack_q ? ST_SEND : ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // outputs and control strobes
    always_comb begin
        guard_end      = (state == ST_GUARD) && etu_end && (guard_cnt == LAST_GUARD);
        load_frame     = ((state == ST_IDLE) && !hold_empty) || (guard_end && nack_q);
        shift_bit      = (state == ST_SEND) && etu_end;
        err_hit        = (state == ST_GUARD) && etu_mid && (guard_cnt == '0) && !line_in;
        set_done       = guard_end && !nack_q;
        line_drive_low = (state == ST_SEND) && !shreg[0];
        irq_tx         = tx_done && tx_irq_en;
        irq_err        = err_status && err_irq_en;
        dma_req        = tx_done && hold_empty;
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= '0;
            shreg     <= '1;
            bit_cnt   <= '0;
            guard_cnt <= '0;
            nack_q    <= 1'b0;
        end else begin
            if (host_wr) begin
                hold_q <= host_data;
            end else if (dma_wr) begin
                hold_q <= dma_data;
            end

            if (load_frame) begin
                shreg   <= {^hold_q, hold_q, 1'b0};
                bit_cnt <= '0;
            end else if (shift_bit) begin
                shreg <= {1'b1, shreg[FRAME_BITS-1:1]};
                if (bit_cnt != LAST_BIT) begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end

            if (state != ST_GUARD) begin
                guard_cnt <= '0;
            end else if (etu_end) begin
                guard_cnt <= guard_cnt + 1'b1;
            end

            if (load_frame) begin
                nack_q <= 1'b0;
            end else if (err_hit) begin
                nack_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/sctx_checker.sv
module sctx_checker (
    input logic clk,
    input logic rst_n,
    input logic in_guard,
    input logic busy,
    input logic line_drive_low,
    input logic hold_empty,
    input logic tx_done,
    input logic err_status,
    input logic irq_tx,
    input logic irq_err,
    input logic dma_req,
    input logic tx_irq_en,
    input logic err_irq_en,
    input logic host_clr_err,
    input logic host_clr_flags,
    input logic dma_wr,
    input logic dma_isel,
    input logic dma_cnt_nz
);
    assert_guard_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_guard |-> !line_drive_low);

    assert_idle_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !line_drive_low);

    assert_irq_err_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_err |-> (err_status && err_irq_en));

    assert_busy_no_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !tx_done);

    assert_done_with_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> hold_empty);

    assert_irq_tx_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_tx |-> (tx_done && tx_irq_en));

    assert_busy_no_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !dma_req);

    assert_dma_keep_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_wr && (dma_isel || !dma_cnt_nz) && !host_clr_flags && hold_empty) |=> hold_empty);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_status && !host_clr_err) |=> err_status);
endmodule

bind cardline_tx sctx_checker u_sctx_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_guard       (state == sctx_pkg::ST_GUARD),
    .busy           (state != sctx_pkg::ST_IDLE),
    .line_drive_low (line_drive_low),
    .hold_empty     (hold_empty),
    .tx_done        (tx_done),
    .err_status     (err_status),
    .irq_tx         (irq_tx),
    .irq_err        (irq_err),
    .dma_req        (dma_req),
    .tx_irq_en      (tx_irq_en),
    .err_irq_en     (err_irq_en),
    .host_clr_err   (host_clr_err),
    .host_clr_flags (host_clr_flags),
    .dma_wr         (dma_wr),
    .dma_isel       (dma_isel),
    .dma_cnt_nz     (dma_cnt_nz)
);

// File: tb/test_cardline_tx.sv
module test_cardline_tx;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] etu_cycles = 12'd8;
    logic        tx_irq_en = 1'b0, err_irq_en = 1'b0;
    logic        host_wr = 1'b0, host_clr_flags = 1'b0, host_clr_err = 1'b0;
    logic [7:0]  host_data = 8'h00, dma_data = 8'h00;
    logic        dma_wr = 1'b0, dma_isel = 1'b0, dma_cnt_nz = 1'b0;
    logic        card_low = 1'b0;
    logic        line_in;
    logic        line_drive_low, hold_empty, tx_done, err_status, irq_tx, irq_err, dma_req;
    int          checks = 0, errors = 0;
    bit          finished = 1'b0;

    assign line_in = !(line_drive_low || card_low);

    always #(CLK_PERIOD/2) clk = ~clk;

    cardline_tx i_cardline_tx (
        .clk(clk), .rst_n(rst_n), .etu_cycles(etu_cycles),
        .tx_irq_en(tx_irq_en), .err_irq_en(err_irq_en),
        .host_wr(host_wr), .host_data(host_data),
        .host_clr_flags(host_clr_flags), .host_clr_err(host_clr_err),
        .dma_wr(dma_wr), .dma_data(dma_data), .dma_isel(dma_isel), .dma_cnt_nz(dma_cnt_nz),
        .line_in(line_in), .line_drive_low(line_drive_low),
        .hold_empty(hold_empty), .tx_done(tx_done), .err_status(err_status),
        .irq_tx(irq_tx), .irq_err(irq_err), .dma_req(dma_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic host_load(input logic [7:0] d, input bit clr);
        @(negedge clk);
        host_wr = 1'b1; host_data = d; host_clr_flags = clr;
        @(negedge clk);
        host_wr = 1'b0; host_clr_flags = 1'b0;
    endtask

    task automatic dma_load(input logic [7:0] d, input bit isel, input bit cnz);
        @(negedge clk);
        dma_wr = 1'b1; dma_data = d; dma_isel = isel; dma_cnt_nz = cnz;
        @(negedge clk);
        dma_wr = 1'b0;
    endtask

    // Watches one character from its start edge to 12 etu later; returns at that negedge.
    task automatic capture(input int etu, input bit nack, output logic [9:0] bits,
                           output bit guard_ok, output bit early_done, output bit err_mid,
                           output bit dma_mid, output bit l_pre, output bit l_post);
        int w = 0;
        int mid = etu / 2;
        bits = '1; guard_ok = 1'b1; early_done = 1'b0; err_mid = 1'b0;
        dma_mid = 1'b0; l_pre = 1'b1; l_post = 1'b0;
        while (!line_drive_low && w < 4000) begin
            @(negedge clk);
            w++;
        end
        for (int n = 0; n <= 12*etu; n++) begin
            if (n < 10*etu && (n % etu) == mid) bits[n/etu] = line_in;
            if (n == etu - 1) l_pre = line_in;
            if (n == etu) l_post = line_in;
            if (n >= 10*etu && n < 12*etu && line_drive_low) guard_ok = 1'b0;
            if (n == 12*etu - 1) early_done = tx_done;
            if (n == 10*etu + mid + 1) begin
                err_mid = err_status;
                dma_mid = dma_req;
            end
            card_low = nack && (n >= 10*etu + 1) && (n < 11*etu + 2);
            if (n < 12*etu) @(negedge clk);
        end
        card_low = 1'b0;
    endtask

    task automatic t_reset;
        check("R9 reset hold_empty", hold_empty, 1);
        check("R9 reset tx_done", tx_done, 1);
        check("R9 reset err_status", err_status, 0);
        check("R2 idle line released", line_drive_low, 0);
        check("R6 dma_req at reset", dma_req, 1);
        host_load(8'h77, 1'b0);
        repeat (5) @(negedge clk);
        check("R9 write alone keeps empty", hold_empty, 1);
        check("R9 write alone no start", line_drive_low, 0);
    endtask

    task automatic t_normal;
        logic [9:0] b; bit g, e, em, dm, lp, lq;
        etu_cycles = 12'd8; tx_irq_en = 1'b1; err_irq_en = 1'b1;
        host_load(8'hA5, 1'b1);
        capture(8, 1'b0, b, g, e, em, dm, lp, lq);
        check("R1 start bit", b[0], 0);
        check("R1 data lsb first", b[8:1], 8'hA5);
        check("R1 even parity", b[9], ^8'hA5);
        check("R2 guard released", g, 1);
        check("R5 done not early", e, 0);
        check("R5 done at 12 etu", tx_done, 1);
        check("R5 empty with done", hold_empty, 1);
        check("R5 irq_tx enabled", irq_tx, 1);
        check("R3 no error flag", err_status, 0);
        check("R6 dma_req after done", dma_req, 1);
    endtask

    task automatic t_retry;
        logic [9:0] b; bit g, e, em, dm, lp, lq;
        host_load(8'h3C, 1'b1);
        capture(8, 1'b1, b, g, e, em, dm, lp, lq);
        check("R1 first try data", b[8:1], 8'h3C);
        check("R3 err set after sample", em, 1);
        check("R6 no dma_req in retry", dm, 0);
        check("R4 done low after error", tx_done, 0);
        check("R3 irq_err raised", irq_err, 1);
        check("R4 resend starts at 12 etu", line_drive_low, 1);
        capture(8, 1'b0, b, g, e, em, dm, lp, lq);
        check("R4 same byte resent", b[8:1], 8'h3C);
        check("R4 resend parity", b[9], ^8'h3C);
        check("R6 no dma_req during resend", dm, 0);
        check("R5 done after clean resend", tx_done, 1);
        check("R8 err sticky after success", err_status, 1);
        @(negedge clk); host_clr_err = 1'b1;
        @(negedge clk); host_clr_err = 1'b0;
        check("R8 err cleared by host", err_status, 0);
        check("R3 irq_err follows err", irq_err, 0);
    endtask

    task automatic t_dma;
        logic [9:0] b; bit g, e, em, dm, lp, lq;
        dma_load(8'h5A, 1'b1, 1'b1);
        repeat (3) @(negedge clk);
        check("R7 isel keeps empty", hold_empty, 1);
        check("R7 isel keeps done", tx_done, 1);
        check("R7 isel no start", line_drive_low, 0);
        dma_load(8'h66, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        check("R7 zero count keeps empty", hold_empty, 1);
        check("R7 zero count no start", line_drive_low, 0);
        dma_load(8'hC3, 1'b0, 1'b1);
        check("R7 auto clear empty", hold_empty, 0);
        capture(8, 1'b0, b, g, e, em, dm, lp, lq);
        check("R7 dma byte sent", b[8:1], 8'hC3);
        check("R5 done after dma frame", tx_done, 1);
    endtask

    task automatic t_etu6;
        logic [9:0] b; bit g, e, em, dm, lp, lq;
        etu_cycles = 12'd6;
        host_load(8'h01, 1'b1);
        capture(6, 1'b0, b, g, e, em, dm, lp, lq);
        check("R10 start low through etu", lp, 0);
        check("R10 bit0 after one etu", lq, 1);
        check("R10 data at etu 6", b[8:1], 8'h01);
        check("R1 parity one", b[9], 1);
        check("R10 done at 12 etu", tx_done, 1);
        check("R10 not early", e, 0);
    endtask

    task automatic t_irq_off;
        logic [9:0] b; bit g, e, em, dm, lp, lq;
        etu_cycles = 12'd8; tx_irq_en = 1'b0; err_irq_en = 1'b0;
        host_load(8'h00, 1'b1);
        capture(8, 1'b1, b, g, e, em, dm, lp, lq);
        check("R3 err set with irq off", err_status, 1);
        check("R3 irq_err masked", irq_err, 0);
        capture(8, 1'b0, b, g, e, em, dm, lp, lq);
        check("R5 done with irq off", tx_done, 1);
        check("R5 irq_tx masked", irq_tx, 0);
        check("R1 zero byte parity", b[9], 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_retry();
        t_dma();
        t_etu6();
        t_irq_off();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule